// File: doc/BRIEF.md
# RGMII Receive Frame Aligner

This block sits behind a double-data-rate input capture stage on a gigabit reduced-pin media interface. The capture stage supplies one nibble taken on the rising edge, one taken on the falling edge and the receive control bit, all in the 125 MHz receive clock domain. The block joins the two nibbles into one byte per clock. It then looks for the start of each frame and passes the frame bytes downstream as a stream, with start-of-frame and end-of-frame markers.

The sending PHY may need more or less time to lock, so the preamble in front of a frame has no fixed length. The aligner accepts any run of 0x55 bytes, and the first 0xD5 byte marks the start. Every byte after the delimiter is passed on, the four frame check bytes included. The block runs a CRC-32 over those bytes and tests the residue. Frames with a CRC mismatch, and frames shorter than the Ethernet minimum, are flagged bad on their last byte. Any other byte value before the delimiter is reported as an alignment error and the frame is dropped. The block then ignores the line until receive control goes low.

Top module: `rgmii_rx_aligner`

## Requirements
- R1: Each assembled byte takes bits 3:0 from the rising-edge nibble and bits 7:4 from the falling-edge nibble of the same clock.
- R2: With receive control high, any number of 0x55 bytes (including none) followed by 0xD5 starts a frame. The first output byte is the byte that follows the 0xD5.
- R3: If receive control is high and a byte other than 0x55 or 0xD5 appears before the delimiter, `align_err` pulses for exactly one cycle and the frame produces no output bytes. Everything after that is ignored until receive control has been low for at least one clock.
- R4: A frame ends on the first clock in which receive control is low. `out_eof` is set on the last byte, which is the final frame check byte, and every byte after the delimiter is output in order.
- R5: `out_sof` is set on the first output byte of each frame and on no other byte. `out_sof`, `out_eof` and `out_bad` are only ever set together with `out_valid`.
- R6: The CRC-32 (reflected, polynomial 0x04C11DB7, initial value all ones) runs over all bytes after the delimiter, including the four check bytes sent least significant byte first. On a correct frame the bit-reversed register equals 0xC704DD7B. Any other value sets `out_bad` on the end byte.
- R7: A frame with fewer than 64 bytes after the delimiter (check bytes included) is flagged with `out_bad`, even when its CRC is correct. A frame of exactly 64 bytes with a correct CRC is good.
- R8: After reset, and while receive control is low, the block outputs nothing (`out_valid` and `align_err` stay 0), whatever byte values are on the nibble inputs.
- R9: `out_bad` is set only together with `out_eof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nib_rise | input | 4 | Nibble captured on the rising edge |
| nib_fall | input | 4 | Nibble captured on the falling edge |
| rx_ctl | input | 1 | Receive control (data valid) bit |
| out_valid | output | 1 | Output byte is valid |
| out_data | output | 8 | Frame byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| out_bad | output | 1 | Frame failed the CRC or length check (with out_eof) |
| align_err | output | 1 | One-cycle pulse: preamble broken before the delimiter |

## Verification
A search state stuck in the wrong place shows up as a shifted or missing first byte. It can also show up as an alignment pulse inside a good preamble, visible about two clocks after the byte that caused it. A wrong CRC register or length counter does not show until the end byte of the frame: the bad flag is wrong there, so frames with a single corrupted byte, runts at 63 bytes and frames of exactly 64 bytes are all driven. A fault in the one-byte hold register shows as a lost or doubled last byte, or as an end marker on the wrong byte, so every byte and the frame length are compared.

// File: rtl/rgmii_rx_pkg.sv
package rgmii_rx_pkg;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,   // ignore the line until rx_ctl is low
    ST_SEEK = 2'd1,   // hunting preamble / delimiter
    ST_DATA = 2'd2    // inside a frame
  } fr_state_e;

  localparam logic [7:0]  PRE_BYTE    = 8'h55;
  localparam logic [7:0]  SFD_BYTE    = 8'hD5;
  localparam logic [31:0] CRC_POLY_R  = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE = 32'hC704DD7B;

  // One byte through the reflected CRC-32, LSB first.
  function automatic logic [31:0] crc32_step(input logic [31:0] crc_in,
                                             input logic [7:0]  din);
    logic [31:0] c;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      c = (c >> 1) ^ (CRC_POLY_R & {32{c[0] ^ din[i]}});
    end
    return c;
  endfunction

  function automatic logic [31:0] bit_rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

endpackage

// File: rtl/rx_byte_pack.sv
module rx_byte_pack #(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NIB_W-1:0]   nib_rise,
  input  logic [NIB_W-1:0]   nib_fall,
  input  logic               rx_ctl,
  output logic [2*NIB_W-1:0] byte_q,
  output logic               ctl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_q <= '0;
      ctl_q  <= 1'b0;
    end else begin
      byte_q <= {nib_fall, nib_rise};
      ctl_q  <= rx_ctl;
    end
  end
endmodule

// File: rtl/rx_frame_check.sv
module rx_frame_check
  import rgmii_rx_pkg::*;
#(
  parameter int MIN_LEN = 64,
  parameter int LEN_W   = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic       crc_ok,
  output logic       long_ok
);
  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_LEN);

  logic [31:0]      crc_r;
  logic [LEN_W-1:0] cnt_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_r <= '1;
      cnt_r <= '0;
    end else if (clr) begin
      crc_r <= '1;
      cnt_r <= '0;
    end else if (en) begin
      crc_r <= crc32_step(crc_r, din);
      if (cnt_r != LEN_MAX) cnt_r <= cnt_r + 1'b1;
    end
  end

  assign crc_ok  = (bit_rev32(crc_r) == CRC_RESIDUE);
  assign long_ok = (cnt_r >= LEN_MIN);

  // R7
  len_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cnt_r >= $past(cnt_r));

  // R7
  len_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_r == '0);
endmodule

// File: rtl/rx_sfd_fsm.sv
module rx_sfd_fsm
  import rgmii_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] byte_q,
  input  logic       ctl_q,
  input  logic       crc_ok,
  input  logic       long_ok,
  output logic       chk_clr,
  output logic       chk_en,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof,
  output logic       out_bad,
  output logic       align_err
);
  fr_state_e  state;
  logic [7:0] pend_byte;
  logic       pend_vld;
  logic       first_pend;

  // named events
  logic sfd_hit, pre_bad, data_take, frame_end;
  assign sfd_hit   = (state == ST_SEEK) && ctl_q && (byte_q == SFD_BYTE);
  assign pre_bad   = (state == ST_SEEK) && ctl_q &&
                     (byte_q != SFD_BYTE) && (byte_q != PRE_BYTE);
  assign data_take = (state == ST_DATA) && ctl_q;
  assign frame_end = (state == ST_DATA) && !ctl_q;

  assign chk_clr = sfd_hit;
  assign chk_en  = data_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_WAIT;
      pend_byte  <= '0;
      pend_vld   <= 1'b0;
      first_pend <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_sof    <= 1'b0;
      out_eof    <= 1'b0;
      out_bad    <= 1'b0;
      align_err  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_bad   <= 1'b0;
      align_err <= 1'b0;
      unique case (state)
        ST_WAIT: if (!ctl_q) state <= ST_SEEK;
        ST_SEEK: begin
          if (sfd_hit) begin
            state      <= ST_DATA;
            pend_vld   <= 1'b0;
            first_pend <= 1'b1;
          end else if (pre_bad) begin
            state     <= ST_WAIT;
            align_err <= 1'b1;
          end
        end
        ST_DATA: begin
          if (data_take) begin
            if (pend_vld) begin
              out_valid  <= 1'b1;
              out_data   <= pend_byte;
              out_sof    <= first_pend;
              first_pend <= 1'b0;
            end
            pend_byte <= byte_q;
            pend_vld  <= 1'b1;
          end else begin
            if (pend_vld) begin
              out_valid <= 1'b1;
              out_data  <= pend_byte;
              out_sof   <= first_pend;
              out_eof   <= 1'b1;
              out_bad   <= !(crc_ok && long_ok);
            end
            pend_vld <= 1'b0;
            state    <= ST_SEEK;
          end
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

  // R9
  bad_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_bad |-> out_eof);

  // R5
  sof_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof || out_eof) |-> out_valid);

  // R3
  align_err_to_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (state == ST_WAIT));

  // R4
  end_after_ctl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> !$past(ctl_q));

  // R8
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_DATA) |=> !out_valid);
endmodule

// File: rtl/rgmii_rx_aligner.sv
module rgmii_rx_aligner #(
  parameter int NIB_W   = 4,
  parameter int MIN_LEN = 64,
  parameter int LEN_W   = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   nib_rise,
  input  logic [3:0]   nib_fall,
  input  logic         rx_ctl,
  output logic         out_valid,
  output logic [7:0]   out_data,
  output logic         out_sof,
  output logic         out_eof,
  output logic         out_bad,
  output logic         align_err
);
  logic [7:0] byte_q;
  logic       ctl_q;
  logic       crc_ok, long_ok, chk_clr, chk_en;

  rx_byte_pack #(.NIB_W(NIB_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .nib_rise(nib_rise), .nib_fall(nib_fall),
    .rx_ctl(rx_ctl), .byte_q(byte_q), .ctl_q(ctl_q)
  );

  rx_frame_check #(.MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_check (
    .clk(clk), .rst_n(rst_n), .clr(chk_clr), .en(chk_en), .din(byte_q),
    .crc_ok(crc_ok), .long_ok(long_ok)
  );

  rx_sfd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .byte_q(byte_q), .ctl_q(ctl_q),
    .crc_ok(crc_ok), .long_ok(long_ok), .chk_clr(chk_clr), .chk_en(chk_en),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .out_bad(out_bad), .align_err(align_err)
  );
endmodule

// File: tb/rgmii_rx_aligner_bench.sv
module rgmii_rx_aligner_bench;
  localparam int CLK_PERIOD = 8;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] nib_rise = '0, nib_fall = '0;
  logic       rx_ctl = 1'b0;
  logic       out_valid, out_sof, out_eof, out_bad, align_err;
  logic [7:0] out_data;

  rgmii_rx_aligner u_rgmii_rx_aligner (
    .clk(clk), .rst_n(rst_n), .nib_rise(nib_rise), .nib_fall(nib_fall),
    .rx_ctl(rx_ctl), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_bad(out_bad),
    .align_err(align_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;

  // expected frame
  logic [7:0] exp_b [0:255];
  int         exp_len;
  // captured
  logic [7:0] got_b [0:255];
  int         got_idx, got_len, frames_done, sof_cnt, align_cnt, stray;
  logic       got_bad;

  // bench CRC: reflected byte-wise, written with a shift of the whole byte
  function automatic logic [31:0] ref_crc(input logic [31:0] c0, input logic [7:0] b);
    logic [31:0] c;
    c = c0 ^ {24'd0, b};
    for (int k = 0; k < 8; k++)
      c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (rst_n) begin
      if (align_err) align_cnt++;
      if (!out_valid && (out_sof || out_eof || out_bad)) stray++;
      if (out_bad && !out_eof) stray++;
      if (out_valid) begin
        if (out_sof) begin got_idx = 0; sof_cnt++; end
        if (got_idx < 256) got_b[got_idx] = out_data;
        got_idx++;
        if (out_eof) begin
          got_len = got_idx; got_bad = out_bad; frames_done++;
        end
      end
    end
  end

  task automatic drive_byte(input logic [7:0] b, input logic ctl);
    @(negedge clk);
    nib_rise = b[3:0];   // R1: low nibble on the rising edge
    nib_fall = b[7:4];
    rx_ctl   = ctl;
  endtask

  task automatic clear_mon();
    got_idx = 0; got_len = -1; frames_done = 0; sof_cnt = 0;
    align_cnt = 0; stray = 0; got_bad = 1'b0;
  endtask

  // preamble length npre, payload len plen, corrupt flips one byte,
  // bad_at>=0 puts 0x5A into the preamble at that position
  task automatic send_frame(input int npre, input int plen, input bit corrupt,
                            input int bad_at);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < plen; i++) begin
      exp_b[i] = 8'($urandom);
      c = ref_crc(c, exp_b[i]);
    end
    c = ~c;
    for (int i = 0; i < 4; i++) exp_b[plen+i] = c[8*i +: 8];
    exp_len = plen + 4;
    if (corrupt) exp_b[$urandom % plen] ^= 8'h10;
    for (int i = 0; i < npre; i++) drive_byte((i == bad_at) ? 8'h5A : 8'h55, 1'b1);
    drive_byte(8'hD5, 1'b1);
    for (int i = 0; i < exp_len; i++) drive_byte(exp_b[i], 1'b1);
    for (int i = 0; i < 6; i++) drive_byte(8'($urandom), 1'b0);
  endtask

  task automatic check_good_frame(input string tag, input bit exp_bad);
    bit same;
    same = (got_len == exp_len);
    for (int i = 0; i < exp_len && i < 256; i++) if (got_b[i] !== exp_b[i]) same = 0;
    check(frames_done == 1, {tag, " R2 one frame"}, frames_done, 1);
    check(got_len == exp_len, {tag, " R4 length"}, got_len, exp_len);
    check(same, {tag, " R1 R4 bytes"}, same, 1);
    check(sof_cnt == 1, {tag, " R5 sof"}, sof_cnt, 1);
    check(got_bad == exp_bad, {tag, " R6 R7 bad flag"}, got_bad, exp_bad);
    check(stray == 0 && align_cnt == 0, {tag, " R9 flags"}, stray + align_cnt, 0);
  endtask

  initial begin
    void'($urandom(32'd12345));
    clear_mon();
    repeat (3) @(negedge clk);
    // R8 reset state
    check(out_valid == 0 && align_err == 0, "R8 reset outputs", out_valid, 0);
    rst_n = 1'b1;
    repeat (3) drive_byte(8'h00, 1'b0);

    // R8: noise with rx_ctl low, including preamble-like bytes
    clear_mon();
    drive_byte(8'h55, 1'b0); drive_byte(8'hD5, 1'b0);
    for (int i = 0; i < 20; i++) drive_byte(8'($urandom), 1'b0);
    check(frames_done == 0 && got_idx == 0, "R8 ctl low ignored", got_idx, 0);
    check(align_cnt == 0, "R8 no align err while idle", align_cnt, 0);

    // R2 directed preamble lengths, R7 boundary 64 bytes good
    clear_mon(); send_frame(7, 60, 0, -1); check_good_frame("pre7 len64", 0);
    clear_mon(); send_frame(1, 80, 0, -1); check_good_frame("pre1", 0);
    clear_mon(); send_frame(0, 70, 0, -1); check_good_frame("pre0", 0);
    clear_mon(); send_frame(15, 100, 0, -1); check_good_frame("pre15", 0);
    // R7 runt of 63 bytes with valid CRC
    clear_mon(); send_frame(7, 59, 0, -1); check_good_frame("R7 runt63", 1);
    // R6 single corrupted byte
    clear_mon(); send_frame(7, 90, 1, -1); check_good_frame("R6 corrupt", 1);

    // R3 broken preamble: frame dropped, one pulse
    clear_mon(); send_frame(7, 64, 0, 3);
    check(frames_done == 0 && got_idx == 0, "R3 dropped frame no output", got_idx, 0);
    check(align_cnt == 1, "R3 single align pulse", align_cnt, 1);
    // R3 recovery: next frame accepted
    clear_mon(); send_frame(5, 64, 0, -1); check_good_frame("R3 recover", 0);

    // random mix
    for (int n = 0; n < 30; n++) begin
      int  pre, len;
      bit  bad;
      pre = $urandom % 12;
      len = 55 + ($urandom % 146);
      bad = ($urandom % 4) == 0;
      clear_mon();
      send_frame(pre, len, bad, -1);
      check_good_frame("random", bad || (len + 4 < 64));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule